// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block generates the column addresses for a single read or write burst inside an open synchronous DRAM row. A controller gives it a start column, a length code and an ordering bit, and pulses a start strobe. From the next clock edge on, the block presents one column per cycle with a valid flag. A last-beat flag marks the final column of a fixed-length burst.

Fixed-length bursts wrap inside the aligned block that the burst length defines, so the upper column bits never change during the burst. A full-page burst walks the whole 1024-column row, wraps from 1023 to 0 and runs until a terminate strobe stops it.

A running burst can be stopped at any cycle by the terminate strobe. It can also be replaced at any cycle by a new start, which takes effect at once. A start that asks for an illegal combination is refused and raises a one-cycle error flag. Command decoding, data, rows, banks and refresh are handled elsewhere.

Top module: `sdram_burst_seq`

## Requirements
- R1: During and just after synchronous reset, valid_o, last_o and err_o are 0.
- R2: A legal start sampled at a rising edge makes valid_o 1 and col_o equal to start_col_i right after that edge, as beat 0.
- R3: With ord_i=0 (sequential), beat k outputs the start column with its low log2(L) bits replaced by (start + k) mod L. L is 1, 2, 4 or 8 for len_i codes 0, 1, 2, 3.
- R4: With ord_i=1 (interleave), beat k outputs the start column with its low log2(L) bits replaced by (start low bits) XOR k.
- R5: A fixed-length burst is valid for exactly L consecutive cycles. last_o is 1 on the final beat only, and valid_o is 0 on the cycle after it.
- R6: len_i code 4 with ord_i=0 is a full-page burst. The column increments by one per cycle, wraps from 1023 to 0, last_o stays 0, and the burst continues until it is terminated or replaced.
- R7: term_i sampled high at an edge without start_i makes valid_o 0 after that edge.
- R8: A legal start during a running burst replaces it. The next output is the new start column as beat 0 of the new burst. A start sampled together with term_i wins over the terminate.
- R9: A start with ord_i=1 and len_i=4, or with len_i codes 5 to 7, is rejected. err_o is 1 for the one cycle after the edge, and any burst in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a new burst (may interrupt) |
| start_col_i | input | 10 | Start column of the new burst |
| len_i | input | 3 | Length code: 0..3 = 1,2,4,8 beats; 4 = full page; 5..7 reserved |
| ord_i | input | 1 | Ordering: 0 sequential, 1 interleave |
| term_i | input | 1 | Terminate the running burst |
| col_o | output | 10 | Current column |
| valid_o | output | 1 | col_o carries a burst beat |
| last_o | output | 1 | Final beat of a fixed-length burst |
| err_o | output | 1 | Previous start was rejected as illegal |

## Verification
A table of bursts covers each fixed length in both orderings. Start columns are chosen so that sequential and interleave orders differ, and some sit near a block edge or at column 1023, so that wrapping inside the block can be told apart from carrying into the upper bits. Further directed runs cover a full page started near 1023 and stopped by terminate, a terminate in mid-burst, and an interrupt that restarts the count. Start and terminate are also driven in the same cycle to show which one wins. Illegal requests are issued both while idle and during a burst, to show that they are rejected without disturbing the running sequence.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;

    localparam int COL_W = 10;
    localparam int LEN_W = 3;
    localparam int MAX_FIXED_CODE = 3;
    localparam int PAGE_CODE = 4;

    typedef logic [COL_W-1:0] col_t;
    typedef logic [LEN_W-1:0] len_code_t;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_ILV = 1'b1
    } order_e;

    typedef struct packed {
        col_t   base;
        col_t   mask;
        order_e order;
        logic   page;
    } burst_cfg_t;

    function automatic logic code_legal(len_code_t code, logic ilv);
        return (int'(code) <= MAX_FIXED_CODE) || ((int'(code) == PAGE_CODE) && !ilv);
    endfunction

    function automatic col_t code_mask(len_code_t code);
        col_t m;
        if (int'(code) == PAGE_CODE) begin
            m = '1;
        end else begin
            m = col_t'((1 << code) - 1);
        end
        return m;
    endfunction

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
    import sdram_burst_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  col_t       start_col_i,
    input  len_code_t  len_i,
    input  logic       ord_i,
    input  logic       term_i,
    output burst_cfg_t cfg_o,
    output col_t       beat_o,
    output logic       active_o,
    output logic       last_o,
    output logic       err_o
);

    burst_cfg_t cfg_q;
    col_t       beat_q;
    logic       active_q;
    logic       err_q;
    logic       legal;
    logic       last;

    assign legal = code_legal(len_i, ord_i);
    assign last  = active_q && !cfg_q.page && (beat_q == cfg_q.mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            beat_q   <= '0;
            active_q <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            err_q <= 1'b0;
            if (start_i && legal) begin
                cfg_q.base  <= start_col_i;
                cfg_q.mask  <= code_mask(len_i);
                cfg_q.order <= order_e'(ord_i);
                cfg_q.page  <= (int'(len_i) == PAGE_CODE);
                beat_q      <= '0;
                active_q    <= 1'b1;
            end else begin
                if (start_i) begin
                    err_q <= 1'b1;
                end
                if (term_i) begin
                    active_q <= 1'b0;
                end else if (active_q) begin
                    if (last) begin
                        active_q <= 1'b0;
                    end else begin
                        beat_q <= beat_q + 1'b1;
                    end
                end
            end
        end
    end

    assign cfg_o    = cfg_q;
    assign beat_o   = beat_q;
    assign active_o = active_q;
    assign last_o   = last;
    assign err_o    = err_q;

    assert_start_R2: assert property (@(posedge clk) disable iff (rst)
        (start_i && code_legal(len_i, ord_i)) |=>
        (active_q && beat_q == '0 && cfg_q.base == $past(start_col_i)));

    assert_advance_R5: assert property (@(posedge clk) disable iff (rst)
        (active_q && !last && !start_i && !term_i) |=>
        (active_q && beat_q == $past(beat_q) + 1'b1));

    assert_end_R5: assert property (@(posedge clk) disable iff (rst)
        (last && !start_i && !term_i) |=> !active_q);

    assert_term_R7: assert property (@(posedge clk) disable iff (rst)
        (term_i && !start_i) |=> !active_q);

    assert_reject_R9: assert property (@(posedge clk) disable iff (rst)
        (start_i && !code_legal(len_i, ord_i)) |=> (err_q && $stable(cfg_q)));

    assert_err_cause_R9: assert property (@(posedge clk) disable iff (rst)
        err_q |-> $past(start_i));

endmodule

// File: rtl/col_gen.sv
module col_gen
    import sdram_burst_pkg::*;
(
    input  burst_cfg_t cfg_i,
    input  col_t       beat_i,
    output col_t       col_o
);

    col_t offset;

    always_comb begin
        if (cfg_i.order == ORD_SEQ) begin
            offset = cfg_i.base + beat_i;
        end else begin
            offset = cfg_i.base ^ beat_i;
        end
        col_o = (cfg_i.base & ~cfg_i.mask) | (offset & cfg_i.mask);
    end

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
    import sdram_burst_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             ord_i,
    input  logic             term_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             err_o
);

    burst_cfg_t cfg;
    col_t       beat;
    col_t       col;

    burst_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .start_col_i(start_col_i),
        .len_i      (len_i),
        .ord_i      (ord_i),
        .term_i     (term_i),
        .cfg_o      (cfg),
        .beat_o     (beat),
        .active_o   (valid_o),
        .last_o     (last_o),
        .err_o      (err_o)
    );

    col_gen u_col (
        .cfg_i (cfg),
        .beat_i(beat),
        .col_o (col)
    );

    assign col_o = col;

    assert_last_valid_R5: assert property (@(posedge clk) disable iff (rst)
        last_o |-> valid_o);

    assert_page_step_R6: assert property (@(posedge clk) disable iff (rst)
        (valid_o && cfg.page && !start_i && !term_i) |=>
        (valid_o && !last_o && col_o == $past(col_o) + 1'b1));

endmodule

// File: tb/sim_sdram_burst_seq.sv
module sim_sdram_burst_seq;

    logic       clk = 1'b0;
    logic       rst;
    logic       start_i;
    logic [9:0] start_col_i;
    logic [2:0] len_i;
    logic       ord_i;
    logic       term_i;
    logic [9:0] col_o;
    logic       valid_o;
    logic       last_o;
    logic       err_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sdram_burst_seq u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
        .len_i(len_i), .ord_i(ord_i), .term_i(term_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .err_o(err_o)
    );

    typedef struct packed {
        logic [9:0] col;
        logic [2:0] code;
        logic       ilv;
        logic [3:0] len;
        logic [9:0] c1;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{10'd5,    3'd2, 1'b0, 4'd4, 10'd6},
        '{10'd5,    3'd2, 1'b1, 4'd4, 10'd4},
        '{10'd13,   3'd3, 1'b0, 4'd8, 10'd14},
        '{10'd13,   3'd3, 1'b1, 4'd8, 10'd12},
        '{10'd7,    3'd1, 1'b0, 4'd2, 10'd6},
        '{10'd7,    3'd1, 1'b1, 4'd2, 10'd6},
        '{10'h2A5,  3'd0, 1'b0, 4'd1, 10'd0},
        '{10'd1023, 3'd3, 1'b0, 4'd8, 10'd1016},
        '{10'd3,    3'd2, 1'b1, 4'd4, 10'd2}
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model_col(int s, int code, bit ilv, int k);
        int n = 1 << code;
        int m = n - 1;
        int low = ilv ? ((s % n) ^ k) : ((s + k) % n);
        return (s - (s % n)) + (low & m);
    endfunction

    task automatic issue(input int col, input int code, input bit ilv, input bit term);
        start_i = 1'b1; start_col_i = 10'(col); len_i = 3'(code); ord_i = ilv; term_i = term;
        @(negedge clk);
        start_i = 1'b0; term_i = 1'b0;
    endtask

    always @(posedge clk) begin
        if (!done && total >= 0) begin
            if ($time > 64'd1000000) begin
                bad++;
                total++;
                $display("FAIL watchdog actual=1 expected=0");
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1; start_i = 0; start_col_i = 0; len_i = 0; ord_i = 0; term_i = 0;
        @(negedge clk); @(negedge clk);
        chk("R1 valid in reset", int'(valid_o), 0);
        chk("R1 last in reset", int'(last_o), 0);
        chk("R1 err in reset", int'(err_o), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid after reset", int'(valid_o), 0);

        // table walk: R2 R3 R4 R5
        for (int v = 0; v < NV; v++) begin
            issue(VECS[v].col, VECS[v].code, VECS[v].ilv, 1'b0);
            for (int k = 0; k < int'(VECS[v].len); k++) begin
                chk("R5 valid during burst", int'(valid_o), 1);
                if (k == 0) chk("R2 first column", int'(col_o), int'(VECS[v].col));
                if (k == 1) chk("R3/R4 second column table", int'(col_o), int'(VECS[v].c1));
                chk(VECS[v].ilv ? "R4 interleave column" : "R3 sequential column",
                    int'(col_o), model_col(VECS[v].col, VECS[v].code, VECS[v].ilv, k));
                chk("R5 last flag", int'(last_o), (k == int'(VECS[v].len) - 1) ? 1 : 0);
                @(negedge clk);
            end
            chk("R5 idle after burst", int'(valid_o), 0);
        end

        // R6 full page across 1023 -> 0, then R7 terminate
        issue(1021, 4, 1'b0, 1'b0);
        for (int k = 0; k < 6; k++) begin
            chk("R6 page column", int'(col_o), (1021 + k) % 1024);
            chk("R6 page no last", int'(last_o), 0);
            chk("R6 page valid", int'(valid_o), 1);
            if (k == 5) term_i = 1'b1;
            @(negedge clk);
        end
        term_i = 1'b0;
        chk("R7 terminate page", int'(valid_o), 0);

        // R7 terminate mid fixed burst
        issue(0, 3, 1'b0, 1'b0);
        @(negedge clk); @(negedge clk);
        chk("R7 beat before term", int'(col_o), 2);
        term_i = 1'b1;
        @(negedge clk);
        term_i = 1'b0;
        chk("R7 terminate fixed", int'(valid_o), 0);
        @(negedge clk);
        chk("R7 stays idle", int'(valid_o), 0);

        // R8 interrupt with new burst
        issue(0, 3, 1'b0, 1'b0);
        @(negedge clk);
        chk("R8 old burst beat1", int'(col_o), 1);
        issue(20, 2, 1'b0, 1'b0);
        for (int k = 0; k < 4; k++) begin
            chk("R8 new burst column", int'(col_o), 20 + k);
            chk("R8 new burst last", int'(last_o), (k == 3) ? 1 : 0);
            @(negedge clk);
        end
        chk("R8 new burst length", int'(valid_o), 0);

        // R8 start wins over terminate
        issue(100, 1, 1'b0, 1'b1);
        chk("R8 start beats term valid", int'(valid_o), 1);
        chk("R8 start beats term col", int'(col_o), 100);
        @(negedge clk); @(negedge clk);

        // R9 illegal while idle
        issue(9, 4, 1'b1, 1'b0);
        chk("R9 err pulse idle", int'(err_o), 1);
        chk("R9 rejected no burst", int'(valid_o), 0);
        @(negedge clk);
        chk("R9 err one cycle", int'(err_o), 0);

        // R9 reserved code during running burst
        issue(40, 2, 1'b0, 1'b0);
        chk("R9 run beat0", int'(col_o), 40);
        issue(200, 6, 1'b0, 1'b0);
        chk("R9 err pulse busy", int'(err_o), 1);
        chk("R9 burst continues", int'(col_o), 41);
        chk("R9 burst still valid", int'(valid_o), 1);
        @(negedge clk);
        chk("R9 burst next beat", int'(col_o), 42);
        chk("R9 err cleared", int'(err_o), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule